// File: doc/BRIEF.md
# Character translation dispatch unit

The unit takes a stream of character bytes from a print data path and, for each byte, reads a 12-bit entry from a 256-entry translation table indexed by that byte. The entry's four flag bits and a delimiter-hold bit carried over from the previous character select one of four actions: print the byte as received, print the table's translated code, start a vertical-format action, or stop on an undefined character.

The table is loaded through a dedicated write port. Bytes arrive on a valid/ready handshake, one byte in flight at a time. Each decided action appears on the outputs for one cycle, together with its operand: a character code or a format argument. A running 8-bit checksum of the accepted bytes is kept for the current transfer. The printing and the paper motion are done by blocks downstream.

Top module: `xlat_dispatch`

## Requirements
- R1: A table write on `tbl_we_i` updates the entry at `tbl_addr_i` from the next cycle on. A byte accepted in the same cycle as a write to its own address is looked up in the old entry.
- R2: Entry flag bits are bit 11 interrupt, bit 10 delimiter, bit 9 translate and bit 8 format. The action code on `act_o` is 0 raw print, 1 translated print, 2 format action, 3 undefined-character stop. With the interrupt bit set, the action is stop if translate is clear or delimiter or hold is set. Otherwise it is format if the format bit is set, and translated print if it is clear.
- R3: With interrupt clear and the format bit set, the action is format if any of translate, delimiter or hold is set, and raw print otherwise.
- R4: With interrupt and format both clear, the action is translated print if any of translate, delimiter or hold is set, and raw print otherwise.
- R5: The decision uses the hold value left by the previous character. After each character, `hold_o` equals that entry's delimiter bit.
- R6: For raw print `act_char_o` is the input byte. For translated print it is entry bits 7:0.
- R7: For a format action `act_slew_o` is entry bit 4 (1 = advance by a line count, 0 = seek a channel) and `act_arg_o` is entry bits 3:0.
- R8: Every decided character sets `undef_o` to 1 if its action is stop and to 0 otherwise. After a stop, `byte_ready_o` stays low until `xfer_start_i` is pulsed.
- R9: `csum_o` adds every accepted byte modulo 256. `xfer_start_i` clears it, and a byte accepted in the same cycle is added to zero.
- R10: A byte accepted at clock edge k gives `act_valid_o` high for exactly the cycle after edge k+1. `byte_ready_o` is low from edge k to edge k+1.
- R11: After reset `byte_ready_o` is 1, and `act_valid_o`, `undef_o`, `hold_o` and `csum_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 8 | Table write address |
| tbl_data_i | input | 12 | Table write data |
| xfer_start_i | input | 1 | Start of a new transfer: clears the checksum and the stop |
| byte_valid_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Input byte |
| byte_ready_o | output | 1 | Unit can accept a byte |
| act_valid_o | output | 1 | Action outputs valid |
| act_o | output | 2 | Action code |
| act_char_o | output | 8 | Character to print |
| act_slew_o | output | 1 | Format mode: 1 line count, 0 channel seek |
| act_arg_o | output | 4 | Format argument |
| undef_o | output | 1 | Last character was undefined |
| hold_o | output | 1 | Delimiter-hold state |
| csum_o | output | 8 | Running byte checksum |

## Verification
The decision is driven through all 32 combinations of the four flag bits and the hold bit. Before each test byte, a primer byte forces hold to the wanted value. Because the entry's low byte differs from the input byte, the two print actions produce different character outputs. A slew entry and a channel entry separate the two format modes. A table write made in the same cycle as a lookup of the same address shows whether the read happens before the write. A sequence of bytes whose sum passes 255 checks the checksum wrap, and a stop followed by a restart checks that the undefined flag stays set until the next character and that bytes are refused while stopped.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int CHAR_W  = 8;
  parameter int ENTRY_W = 12;
  parameter int ARG_W   = 4;

  localparam int DEPTH     = 1 << CHAR_W;
  localparam int FL_INT    = 11;
  localparam int FL_DELIM  = 10;
  localparam int FL_XLAT   = 9;
  localparam int FL_FMT    = 8;
  localparam int SLEW_BIT  = 4;

  typedef enum logic [1:0] {
    ACT_RAW  = 2'd0,
    ACT_XLAT = 2'd1,
    ACT_FMT  = 2'd2,
    ACT_STOP = 2'd3
  } act_e;
endpackage

// File: rtl/xlat_ram.sv
module xlat_ram
  import xlat_pkg::*;
(
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [CHAR_W-1:0]  waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic               re_i,
  input  logic [CHAR_W-1:0]  raddr_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  // read-before-write on a shared address
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/xlat_decide.sv
module xlat_decide
  import xlat_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [CHAR_W-1:0]  raw_i,
  input  logic               hold_i,
  output act_e               act_o,
  output logic [CHAR_W-1:0]  char_o,
  output logic               slew_o,
  output logic [ARG_W-1:0]   arg_o,
  output logic               delim_o
);
  logic f_int, f_dl, f_xl, f_fmt, qual;

  assign f_int   = entry_i[FL_INT];
  assign f_dl    = entry_i[FL_DELIM];
  assign f_xl    = entry_i[FL_XLAT];
  assign f_fmt   = entry_i[FL_FMT];
  assign qual    = f_xl | f_dl | hold_i;
  assign delim_o = f_dl;

  always_comb begin
    if (f_int) begin
      if (!f_xl || f_dl || hold_i) act_o = ACT_STOP;
      else if (f_fmt)              act_o = ACT_FMT;
      else                         act_o = ACT_XLAT;
    end else if (f_fmt) begin
      act_o = qual ? ACT_FMT : ACT_RAW;
    end else begin
      act_o = qual ? ACT_XLAT : ACT_RAW;
    end
  end

  assign char_o = (act_o == ACT_RAW) ? raw_i : entry_i[CHAR_W-1:0];
  assign slew_o = entry_i[SLEW_BIT];
  assign arg_o  = entry_i[ARG_W-1:0];
endmodule

// File: rtl/xlat_dispatch.sv
module xlat_dispatch
  import xlat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [CHAR_W-1:0]  tbl_addr_i,
  input  logic [ENTRY_W-1:0] tbl_data_i,
  input  logic               xfer_start_i,
  input  logic               byte_valid_i,
  input  logic [CHAR_W-1:0]  byte_i,
  output logic               byte_ready_o,
  output logic               act_valid_o,
  output logic [1:0]         act_o,
  output logic [CHAR_W-1:0]  act_char_o,
  output logic               act_slew_o,
  output logic [ARG_W-1:0]   act_arg_o,
  output logic               undef_o,
  output logic               hold_o,
  output logic [CHAR_W-1:0]  csum_o
);
  logic               busy_q, stop_q, hold_q, undef_q, accept;
  logic [CHAR_W-1:0]  raw_q, csum_q, csum_base;
  logic [ENTRY_W-1:0] entry;
  act_e               act_d;
  logic [CHAR_W-1:0]  char_d;
  logic               slew_d, delim_d;
  logic [ARG_W-1:0]   arg_d;

  assign byte_ready_o = !busy_q && !stop_q;
  assign accept       = byte_valid_i && byte_ready_o;
  assign csum_base    = xfer_start_i ? '0 : csum_q;

  xlat_ram i_ram (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .re_i    (accept),
    .raddr_i (byte_i),
    .rdata_o (entry)
  );

  xlat_decide i_decide (
    .entry_i (entry),
    .raw_i   (raw_q),
    .hold_i  (hold_q),
    .act_o   (act_d),
    .char_o  (char_d),
    .slew_o  (slew_d),
    .arg_o   (arg_d),
    .delim_o (delim_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      stop_q      <= 1'b0;
      hold_q      <= 1'b0;
      undef_q     <= 1'b0;
      raw_q       <= '0;
      csum_q      <= '0;
      act_valid_o <= 1'b0;
      act_o       <= ACT_RAW;
      act_char_o  <= '0;
      act_slew_o  <= 1'b0;
      act_arg_o   <= '0;
    end else begin
      busy_q      <= accept;
      act_valid_o <= busy_q;
      csum_q      <= accept ? csum_base + byte_i : csum_base;
      if (accept) raw_q <= byte_i;
      if (busy_q) begin
        hold_q     <= delim_d;
        undef_q    <= (act_d == ACT_STOP);
        act_o      <= act_d;
        act_char_o <= char_d;
        act_slew_o <= slew_d;
        act_arg_o  <= arg_d;
      end
      stop_q <= (busy_q && act_d == ACT_STOP) || (stop_q && !xfer_start_i);
    end
  end

  assign undef_o = undef_q;
  assign hold_o  = hold_q;
  assign csum_o  = csum_q;
endmodule

// File: rtl/xlat_dispatch_chk.sv
module xlat_dispatch_chk
  import xlat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_start_i,
  input logic              byte_valid_i,
  input logic [CHAR_W-1:0] byte_i,
  input logic              byte_ready_o,
  input logic              act_valid_o,
  input logic [1:0]        act_o,
  input logic              undef_o,
  input logic              hold_o,
  input logic [CHAR_W-1:0] csum_o
);
  // R10
  act_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> $past(byte_valid_i && byte_ready_o, 2));

  // R10
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_ready_o) |=> !byte_ready_o);

  // R8
  stop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_valid_o && act_o == 2'd3) |-> (undef_o && !byte_ready_o));

  // R5
  raw_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_valid_o && act_o == 2'd0) |-> !hold_o);

  // R9
  csum_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_ready_o) |=>
      csum_o == CHAR_W'(($past(xfer_start_i) ? '0 : $past(csum_o)) + $past(byte_i)));
endmodule

bind xlat_dispatch xlat_dispatch_chk i_chk (.*);

// File: tb/test_xlat_dispatch.sv
`timescale 1ns/1ps
module test_xlat_dispatch;
  logic        clk = 0, rst_ni = 0;
  logic        tbl_we = 0, start = 0, bvalid = 0;
  logic [7:0]  taddr = 0, bdata = 0;
  logic [11:0] tdata = 0;
  logic        ready, avalid, slew, undef, hold;
  logic [1:0]  act;
  logic [7:0]  achar, csum;
  logic [3:0]  arg;
  int          n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  xlat_dispatch i_xlat_dispatch (
    .clk_i(clk), .rst_ni(rst_ni), .tbl_we_i(tbl_we), .tbl_addr_i(taddr),
    .tbl_data_i(tdata), .xfer_start_i(start), .byte_valid_i(bvalid),
    .byte_i(bdata), .byte_ready_o(ready), .act_valid_o(avalid), .act_o(act),
    .act_char_o(achar), .act_slew_o(slew), .act_arg_o(arg), .undef_o(undef),
    .hold_o(hold), .csum_o(csum)
  );

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk); tbl_we = 1; taddr = a; tdata = d;
    @(posedge clk); #1 tbl_we = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); bvalid = 1; bdata = b;
    @(posedge clk); #1 bvalid = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
  endtask

  function automatic logic [1:0] model(input logic [3:0] f, input logic h);
    logic i = f[3], d = f[2], x = f[1], p = f[0];
    if (i) return (!x || d || h) ? 2'd3 : (p ? 2'd2 : 2'd1);
    if (p) return (x || d || h) ? 2'd2 : 2'd0;
    return (x || d || h) ? 2'd1 : 2'd0;
  endfunction

  task automatic t_reset();
    chk("R11 ready", 12'(ready), 12'd1);
    chk("R11 valid", 12'(avalid), 12'd0);
    chk("R11 undef", 12'(undef), 12'd0);
    chk("R11 hold", 12'(hold), 12'd0);
    chk("R11 csum", 12'(csum), 12'd0);
  endtask

  task automatic t_table();
    for (int f = 0; f < 16; f++) begin
      for (int h = 0; h < 2; h++) begin
        logic [1:0] e;
        send(h ? 8'h02 : 8'h01);
        chk("R5 primer hold", 12'(hold), 12'(h));
        send(8'h80 + 8'(f));
        e = model(4'(f), h[0]);
        chk(f[3] ? "R2 act" : (f[0] ? "R3 act" : "R4 act"), 12'(act), 12'(e));
        chk("R5 hold", 12'(hold), 12'(f[2]));
        chk("R8 undef", 12'(undef), 12'(e == 2'd3));
        if (e == 2'd0) chk("R6 raw char", 12'(achar), 12'h80 + 12'(f));
        if (e == 2'd1) chk("R6 xlat char", 12'(achar), 12'h60 + 12'(f));
        if (e == 2'd2) chk("R7 search arg", {7'd0, slew, arg}, 12'(f));
        if (e == 2'd3) restart();
      end
    end
  endtask

  task automatic t_slew();
    send(8'h01);
    send(8'h03);
    chk("R7 act", 12'(act), 12'd2);
    chk("R7 slew", 12'(slew), 12'd1);
    chk("R7 arg", 12'(arg), 12'd5);
  endtask

  task automatic t_stop();
    send(8'h04);
    chk("R8 stop act", 12'(act), 12'd3);
    chk("R8 undef set", 12'(undef), 12'd1);
    chk("R8 refused", 12'(ready), 12'd0);
    restart();
    chk("R8 ready again", 12'(ready), 12'd1);
    chk("R8 undef kept", 12'(undef), 12'd1);
    send(8'h01);
    chk("R8 undef cleared", 12'(undef), 12'd0);
  endtask

  task automatic t_timing();
    @(negedge clk); bvalid = 1; bdata = 8'h01;
    @(posedge clk); #1 bvalid = 0;
    @(negedge clk);
    chk("R10 busy", 12'(ready), 12'd0);
    chk("R10 early", 12'(avalid), 12'd0);
    @(negedge clk);
    chk("R10 valid", 12'(avalid), 12'd1);
    chk("R10 ready", 12'(ready), 12'd1);
    @(negedge clk);
    chk("R10 one cycle", 12'(avalid), 12'd0);
  endtask

  task automatic t_csum();
    restart();
    chk("R9 cleared", 12'(csum), 12'd0);
    send(8'h85); send(8'h86); send(8'h83);
    chk("R9 wrap sum", 12'(csum), 12'h08E);
    restart();
    chk("R9 start clears", 12'(csum), 12'd0);
  endtask

  task automatic t_collide();
    send(8'h01);
    @(negedge clk);
    tbl_we = 1; taddr = 8'h05; tdata = 12'h2CD;
    bvalid = 1; bdata = 8'h05;
    @(posedge clk); #1 tbl_we = 0; bvalid = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 old entry", 12'(achar), 12'h0AB);
    send(8'h05);
    chk("R1 new entry", 12'(achar), 12'h0CD);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    wr(8'h01, 12'h000);
    wr(8'h02, 12'h400);
    wr(8'h03, 12'h315);
    wr(8'h04, 12'h800);
    wr(8'h05, 12'h2AB);
    for (int f = 0; f < 16; f++) wr(8'h80 + 8'(f), {4'(f), 8'h60 + 8'(f)});
    @(negedge clk);
    t_reset();
    t_table();
    t_slew();
    t_stop();
    t_timing();
    t_csum();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule